// File: doc/BRIEF.md
# Global Error Status and Capture Unit

This block gathers error pulses from five groups of an accelerator management function: the management engine itself, two PCIe links, and a RAS pair split into non-fatal and catastrophic/fatal classes. Each group has a 64-bit mask and a 64-bit sticky status register. An error input bit sets its status bit only while the matching mask bit is 0. The status registers of the engine and the two links are cleared by writing ones back. The two RAS status registers cannot be changed from the bus.

Alongside the groups, the unit records which error arrived first after a fully clean state, and which distinct error followed it. A 3-bit injection field drives chosen RAS error sources continuously, so that software can exercise its error handling through the normal status path.

Software reaches all state through a flat 64-bit register bus. Writes take effect at the clock edge and reads are combinational. The intended sequence is as follows: software sets a group's mask to all ones, reads its status, writes the same value back to clear it, and then restores the mask.

Top module: `gerr_unit`

## Requirements
- R1: After reset every mask register reads all ones, and every status register, both capture registers and the injection field read zero.
- R2: A status bit becomes 1 at the clock edge where its error input is 1 and its mask bit is 0, and it stays 1 until cleared. An error input whose mask bit is 1 leaves its status bit unchanged.
- R3: Writing the engine, link-0 or link-1 status register clears every status bit whose write-data bit is 1 and leaves all other bits unchanged.
- R4: If an unmasked error and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Writes to the non-fatal and catastrophic/fatal status registers have no effect.
- R6: The injection register stores write-data bits [2:0]; its bits [63:3] always read 0.
- R7: While injection bit 0 is set it drives catastrophic/fatal error bit 0, injection bit 1 drives catastrophic/fatal bit 1, and injection bit 2 drives non-fatal bit 0.
- R8: Capture words use this layout: bit 63 = valid, bits [10:8] = group id (0 engine, 1 link-0, 2 link-1, 3 non-fatal, 4 catastrophic/fatal), bits [5:0] = bit index, and all other bits 0. The first-error register takes the first newly recorded error when all status registers are clear. Among simultaneous errors, the lowest group id wins, and then the lowest bit index.
- R9: The next-error register takes the next newly recorded error that differs from the first one. This can be the runner-up in the same cycle. Once filled, it does not change.
- R10: Both capture registers return to 0 one clock after every status register is zero.
- R11: With parameter REVISION = 0, bit 6 of the engine mask (mailbox parity) always reads 1 and cannot be cleared.
- R12: The register offsets are as follows. Engine mask is 0x08 and status is 0x10. Link-0 mask is 0x18 and status is 0x20. Link-1 mask is 0x28 and status is 0x30. First error is at 0x38 and next error at 0x40. Non-fatal mask is 0x48 and status is 0x50. Catastrophic/fatal mask is 0x58 and status is 0x60. Injection is at 0x68. Mask registers can be read and written. Any other offset, including a misaligned one, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte offset of the register accessed |
| bus_we_i | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Combinational read data for bus_addr_i |
| mgmt_err_i | input | 64 | Management-engine error inputs |
| link0_err_i | input | 64 | PCIe link 0 error inputs |
| link1_err_i | input | 64 | PCIe link 1 error inputs |
| nonfatal_err_i | input | 64 | Non-fatal RAS error inputs |
| catfatal_err_i | input | 64 | Catastrophic/fatal RAS error inputs |

## Verification
On every cycle, the assertions check the status registers: they are sticky, masked inputs never set a bit, a set wins over a same-cycle clear, and RAS status never falls. They also check that the next-error slot never fills without the first, and that capture clears after a clean cycle. Only the bench scenarios can show the bus-visible side of the block: the offset decode, the capture word layout and its priority order, the injection mapping, and the forced mailbox-parity mask bit.

// File: rtl/gerr_pkg.sv
`timescale 1ns / 1ps
package gerr_pkg;
  localparam int DATA_W    = 64;
  localparam int NUM_GRP   = 5;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int GID_W     = 3;
  localparam int INJ_W     = 3;
  localparam int CAP_VALID = DATA_W - 1;
  localparam int CAP_GID_LSB = 8;
  localparam int MBOX_PARITY_BIT = 6;
  localparam int NUM_W1C_GRP = 3;

  typedef enum logic [GID_W-1:0] {
    GRP_MGMT = 3'd0, GRP_LINK0 = 3'd1, GRP_LINK1 = 3'd2,
    GRP_NONFATAL = 3'd3, GRP_CATFATAL = 3'd4
  } grp_e;

  localparam logic [7:0] OFS_MASK [NUM_GRP] = '{8'h08, 8'h18, 8'h28, 8'h48, 8'h58};
  localparam logic [7:0] OFS_STAT [NUM_GRP] = '{8'h10, 8'h20, 8'h30, 8'h50, 8'h60};
  localparam logic [7:0] OFS_FIRST = 8'h38;
  localparam logic [7:0] OFS_NEXT  = 8'h40;
  localparam logic [7:0] OFS_INJ   = 8'h68;

  // injection routing
  localparam int INJ_NF_BIT  = 0;
  localparam int INJ_CF_LSB  = 0;

  typedef struct packed {
    logic             hit;
    logic [GID_W-1:0] gid;
    logic [IDX_W-1:0] idx;
  } pick_t;

  function automatic logic [DATA_W-1:0] cap_word(pick_t p);
    logic [DATA_W-1:0] w;
    w = '0;
    if (p.hit) begin
      w[CAP_VALID] = 1'b1;
      w[CAP_GID_LSB +: GID_W] = p.gid;
      w[IDX_W-1:0] = p.idx;
    end
    return w;
  endfunction
endpackage

// File: rtl/gerr_group.sv
`timescale 1ns / 1ps
module gerr_group #(
  parameter int          W          = 64,
  parameter bit          CLR_EN     = 1'b1,
  parameter logic [W-1:0] MASK_FORCE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] err_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] status_o,
  output logic [W-1:0] new_o
);
  logic [W-1:0] mask_q, status_q, set_v, clr_eff;

  assign clr_eff = CLR_EN ? clr_i : '0;
  assign set_v   = err_i & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      status_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i | MASK_FORCE;
      status_q <= (status_q & ~clr_eff) | set_v;
    end
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign new_o    = set_v & ~status_q;

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_eff)) == $past(status_q & ~clr_eff)));

  assert_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(mask_q)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(err_i & ~mask_q)) == $past(err_i & ~mask_q)));

  generate
    if (!CLR_EN) begin : g_ro
      assert_ro_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_q & $past(status_q)) == $past(status_q)));
    end
  endgenerate
endmodule

// File: rtl/gerr_capture.sv
`timescale 1ns / 1ps
module gerr_capture
  import gerr_pkg::*;
#(
  parameter int NG = NUM_GRP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NG*DATA_W-1:0] new_i,
  input  logic                 all_zero_i,
  output logic [DATA_W-1:0]    first_o,
  output logic [DATA_W-1:0]    next_o
);
  localparam int FLAT_W = NG * DATA_W;

  pick_t first_q, next_q, p1, p2, base;
  logic  eff_first;
  logic [FLAT_W-1:0] base_oh;

  // lowest group, then lowest bit, wins
  function automatic pick_t find(logic [FLAT_W-1:0] v);
    pick_t r;
    r = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      for (int b = DATA_W - 1; b >= 0; b--) begin
        if (v[g*DATA_W + b]) begin
          r.hit = 1'b1;
          r.gid = GID_W'(g);
          r.idx = IDX_W'(b);
        end
      end
    end
    return r;
  endfunction

  always_comb begin
    eff_first = first_q.hit && !all_zero_i;
    p1        = find(new_i);
    base      = eff_first ? first_q : p1;
    base_oh   = '0;
    if (base.hit)
      base_oh = FLAT_W'(1) << (int'(base.gid) * DATA_W + int'(base.idx));
    p2 = find(new_i & ~base_oh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      next_q  <= '0;
    end else if (!eff_first) begin
      if (p1.hit) begin
        first_q <= p1;
        next_q  <= p2;
      end else if (all_zero_i) begin
        first_q <= '0;
        next_q  <= '0;
      end
    end else if (!next_q.hit && p2.hit) begin
      next_q <= p2;
    end
  end

  assign first_o = cap_word(first_q);
  assign next_o  = cap_word(next_q);

  assert_next_needs_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_q.hit |-> first_q.hit);

  assert_capture_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_zero_i && !(|new_i)) |=> (!first_q.hit && !next_q.hit));
endmodule

// File: rtl/gerr_unit.sv
`timescale 1ns / 1ps
module gerr_unit
  import gerr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REVISION = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] mgmt_err_i,
  input  logic [DATA_W-1:0] link0_err_i,
  input  logic [DATA_W-1:0] link1_err_i,
  input  logic [DATA_W-1:0] nonfatal_err_i,
  input  logic [DATA_W-1:0] catfatal_err_i
);
  localparam logic [DATA_W-1:0] MBOX_FORCE =
      (REVISION == 0) ? (DATA_W'(1) << MBOX_PARITY_BIT) : '0;

  logic [DATA_W-1:0] err_v  [NUM_GRP];
  logic [DATA_W-1:0] mask_v [NUM_GRP];
  logic [DATA_W-1:0] stat_v [NUM_GRP];
  logic [NUM_GRP*DATA_W-1:0] new_flat;
  logic [INJ_W-1:0]  inj_q;
  logic [DATA_W-1:0] first_w, next_w;
  logic              all_zero;

  function automatic logic at_ofs(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // injected sources OR into the RAS groups
  always_comb begin
    err_v[GRP_MGMT]     = mgmt_err_i;
    err_v[GRP_LINK0]    = link0_err_i;
    err_v[GRP_LINK1]    = link1_err_i;
    err_v[GRP_NONFATAL] = nonfatal_err_i;
    err_v[GRP_NONFATAL][INJ_NF_BIT] = nonfatal_err_i[INJ_NF_BIT] | inj_q[2];
    err_v[GRP_CATFATAL] = catfatal_err_i;
    err_v[GRP_CATFATAL][INJ_CF_LSB +: 2] = catfatal_err_i[INJ_CF_LSB +: 2] | inj_q[1:0];
  end

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic              mask_we;
      logic [DATA_W-1:0] clr;
      assign mask_we = bus_we_i && at_ofs(bus_addr_i, OFS_MASK[g]);
      assign clr     = (bus_we_i && at_ofs(bus_addr_i, OFS_STAT[g])) ? bus_wdata_i : '0;

      gerr_group #(
        .W         (DATA_W),
        .CLR_EN    (g < NUM_W1C_GRP),
        .MASK_FORCE((g == GRP_MGMT) ? MBOX_FORCE : {DATA_W{1'b0}})
      ) u_grp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .err_i       (err_v[g]),
        .mask_we_i   (mask_we),
        .mask_wdata_i(bus_wdata_i),
        .clr_i       (clr),
        .mask_o      (mask_v[g]),
        .status_o    (stat_v[g]),
        .new_o       (new_flat[g*DATA_W +: DATA_W])
      );
    end
  endgenerate

  always_comb begin
    all_zero = 1'b1;
    for (int g = 0; g < NUM_GRP; g++)
      if (|stat_v[g]) all_zero = 1'b0;
  end

  gerr_capture #(.NG(NUM_GRP)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .new_i     (new_flat),
    .all_zero_i(all_zero),
    .first_o   (first_w),
    .next_o    (next_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   inj_q <= '0;
    else if (bus_we_i && at_ofs(bus_addr_i, OFS_INJ)) inj_q <= bus_wdata_i[INJ_W-1:0];
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (at_ofs(bus_addr_i, OFS_MASK[g])) bus_rdata_o = mask_v[g];
      if (at_ofs(bus_addr_i, OFS_STAT[g])) bus_rdata_o = stat_v[g];
    end
    if (at_ofs(bus_addr_i, OFS_FIRST)) bus_rdata_o = first_w;
    if (at_ofs(bus_addr_i, OFS_NEXT))  bus_rdata_o = next_w;
    if (at_ofs(bus_addr_i, OFS_INJ))   bus_rdata_o = DATA_W'(inj_q);
  end

  assert_inj_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (REVISION == 0) |-> mask_v[GRP_MGMT][MBOX_PARITY_BIT]);
endmodule

// File: tb/gerr_unit_test.sv
`timescale 1ns / 1ps
module gerr_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [63:0] bus_wdata_i = '0;
  logic [63:0] bus_rdata_o;
  logic [63:0] mgmt_err_i = '0, link0_err_i = '0, link1_err_i = '0;
  logic [63:0] nonfatal_err_i = '0, catfatal_err_i = '0;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gerr_unit uut (.*);

  function automatic logic [63:0] cap(int g, int i);
    return (64'd1 << 63) | (64'(g) << 8) | 64'(i);
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [63:0] exp);
    bus_addr_i = a;
    #1;
    chk(tag, bus_rdata_o, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic pulse(logic [63:0] m, l0, l1, nf, cf);
    @(negedge clk_i);
    mgmt_err_i = m; link0_err_i = l0; link1_err_i = l1;
    nonfatal_err_i = nf; catfatal_err_i = cf;
    @(negedge clk_i);
    mgmt_err_i = '0; link0_err_i = '0; link1_err_i = '0;
    nonfatal_err_i = '0; catfatal_err_i = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 mgmt mask", 8'h08, '1);
    rd_chk("R1 link0 mask", 8'h18, '1);
    rd_chk("R1 link1 mask", 8'h28, '1);
    rd_chk("R1 nf mask", 8'h48, '1);
    rd_chk("R1 cf mask", 8'h58, '1);
    rd_chk("R1 mgmt status", 8'h10, '0);
    rd_chk("R1 cf status", 8'h60, '0);
    rd_chk("R1 first", 8'h38, '0);
    rd_chk("R1 next", 8'h40, '0);
    rd_chk("R1 inject", 8'h68, '0);
  endtask

  task automatic t_masked();
    pulse(64'hFF, '1, '1, '1, 64'hF0);
    rd_chk("R2 masked mgmt", 8'h10, '0);
    rd_chk("R2 masked link0", 8'h20, '0);
    rd_chk("R2 masked nf", 8'h50, '0);
  endtask

  task automatic t_mask_rev();
    wr(8'h08, '0);
    rd_chk("R11 mbox bit forced", 8'h08, 64'h40);
    wr(8'h18, '0);
    wr(8'h28, '0);
    rd_chk("R12 link0 mask rw", 8'h18, '0);
    pulse(64'h40, '0, '0, '0, '0);
    rd_chk("R11 mbox error ignored", 8'h10, '0);
  endtask

  task automatic t_sticky_capture();
    pulse(64'h8, '0, '0, '0, '0);
    rd_chk("R2 set", 8'h10, 64'h8);
    repeat (3) @(negedge clk_i);
    rd_chk("R2 sticky", 8'h10, 64'h8);
    rd_chk("R8 first", 8'h38, cap(0, 3));
    rd_chk("R9 next empty", 8'h40, '0);
    pulse('0, 64'd1 << 10, '0, '0, '0);
    rd_chk("R9 next", 8'h40, cap(1, 10));
    pulse('0, '0, 64'h2, '0, '0);
    rd_chk("R9 next held", 8'h40, cap(1, 10));
    rd_chk("R8 first held", 8'h38, cap(0, 3));
  endtask

  task automatic t_w1c();
    wr(8'h30, 64'h0);
    rd_chk("R3 zero write keeps", 8'h30, 64'h2);
    wr(8'h30, 64'h2);
    rd_chk("R3 link1 cleared", 8'h30, '0);
    wr(8'h20, (64'd1 << 10) | (64'd1 << 11));
    rd_chk("R3 link0 cleared", 8'h20, '0);
    rd_chk("R10 not yet clear", 8'h38, cap(0, 3));
    wr(8'h10, 64'h8);
    rd_chk("R3 mgmt cleared", 8'h10, '0);
    @(negedge clk_i);
    rd_chk("R10 first cleared", 8'h38, '0);
    rd_chk("R10 next cleared", 8'h40, '0);
  endtask

  task automatic t_priority();
    pulse(64'd1 << 9, 64'h10, 64'h1, '0, '0);
    rd_chk("R8 priority first", 8'h38, cap(0, 9));
    rd_chk("R9 same-cycle next", 8'h40, cap(1, 4));
    wr(8'h10, '1);
    wr(8'h20, '1);
    wr(8'h30, '1);
    @(negedge clk_i);
    rd_chk("R10 cleared again", 8'h38, '0);
  endtask

  task automatic t_set_wins();
    pulse('0, 64'h20, '0, '0, '0);
    @(negedge clk_i);
    bus_addr_i = 8'h20; bus_wdata_i = 64'h20; bus_we_i = 1'b1;
    link0_err_i = 64'h20;
    @(negedge clk_i);
    bus_we_i = 1'b0; link0_err_i = '0;
    rd_chk("R4 set wins", 8'h20, 64'h20);
    wr(8'h20, 64'h20);
    rd_chk("R4 later clear", 8'h20, '0);
    @(negedge clk_i);
  endtask

  task automatic t_unmapped();
    wr(8'h00, '1);
    wr(8'h70, '1);
    wr(8'h38, '1);
    rd_chk("R12 read 0x00", 8'h00, '0);
    rd_chk("R12 read 0x70", 8'h70, '0);
    rd_chk("R12 read 0x78", 8'h78, '0);
    rd_chk("R12 misaligned", 8'h09, '0);
    rd_chk("R12 first not writable", 8'h38, '0);
    rd_chk("R12 mgmt mask intact", 8'h08, 64'h40);
  endtask

  task automatic t_inject_ro();
    wr(8'h68, '1);
    rd_chk("R6 inject field", 8'h68, 64'h7);
    rd_chk("R7 nf masked", 8'h50, '0);
    wr(8'h48, '0);
    wr(8'h58, '0);
    @(negedge clk_i);
    rd_chk("R7 nf injected", 8'h50, 64'h1);
    rd_chk("R7 cf injected", 8'h60, 64'h3);
    rd_chk("R8 first injected", 8'h38, cap(3, 0));
    rd_chk("R9 next injected", 8'h40, cap(4, 0));
    wr(8'h68, 64'h0);
    rd_chk("R6 inject off", 8'h68, '0);
    wr(8'h50, '1);
    wr(8'h60, '1);
    rd_chk("R5 nf read-only", 8'h50, 64'h1);
    rd_chk("R5 cf read-only", 8'h60, 64'h3);
    pulse('0, '0, '0, 64'h80, '0);
    rd_chk("R2 nf set", 8'h50, 64'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_masked();
    t_mask_rev();
    t_sticky_capture();
    t_w1c();
    t_priority();
    t_set_wins();
    t_unmapped();
    t_inject_ro();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule